// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block sits between a digitised three-level PWM command and the two gate drivers of a synchronous buck stage. Each clock it turns the command into a high-side enable and a low-side enable, and it never lets the two overlap. Every off-to-on change of either gate waits for a break-before-make gap. A command that stays in the middle tri-state band long enough switches both gates off. When the command leaves the band, the next gate waits a separate quit delay before it turns on.

An active-low mode select picks between forced PWM and skip mode. In skip mode, a zero-current flag seen while the command is low turns the low side off. The low side then stays off until the command next goes high, which gives diode emulation at light load. The enable input and a fault-off request override everything else. All timing is given as parameters in clock cycles. The defaults assume a 200 MHz clock: 4 cycles of dead time, 8 cycles of quit delay and 24 cycles of tri-state dwell.

Top module: `gate_drive_seq`

## Requirements
- R1: During reset both gates are low. After reset, the first gate turns on only on the DEAD_CYC-th clock edge that samples an enabled drive command.
- R2: If en is low or fault_off is high at a clock edge, both gates are low after that edge. Any pending turn-on is cancelled. After release, a gate turns on only on the DEAD_CYC-th following edge.
- R3: pwm_code 2'b01 means high: it drives gate_hi=1 and gate_lo=0. pwm_code 2'b00 means low: it drives gate_hi=0 and gate_lo=1.
- R4: gate_hi and gate_lo are never high in the same cycle.
- R5: When one gate is switched off to change sides, both gates stay low for exactly DEAD_CYC cycles before the other gate turns on. This holds in both directions.
- R6: pwm_code 2'b10 or 2'b11 means the tri-state band. Both gates go low on the edge that samples this code for the TRI_CYC-th consecutive time. A shorter stay in the band leaves the gates unchanged.
- R7: After tri-state has taken effect, a new high or low code turns its gate on exactly QUIT_CYC edges after the edge that first samples it.
- R8: With pwm_mode=0 (skip), pwm_code low and zc_det high at an edge, gate_lo is low after that edge.
- R9: Once skip mode has turned the low side off, it stays off even after zc_det falls. Only a high code releases it. If the gates have already been off for at least DEAD_CYC cycles, the high side then turns on at the first edge.
- R10: With pwm_mode=1 (forced PWM), zc_det has no effect and gate_lo stays high during a low code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; low forces both gates off |
| pwm_code | input | 2 | Digitised PWM level: 00 low, 01 high, 1x tri-state band |
| pwm_mode | input | 1 | 1 = forced PWM, 0 = skip mode |
| zc_det | input | 1 | Inductor zero-current flag |
| fault_off | input | 1 | Fault request; high forces both gates off |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |

## Verification
A fault-off request can land on the same edge as a dead-time count that has just expired and is about to turn a gate on. The bench provokes this by raising fault_off exactly one cycle before the low side is due. It passes if the gate stays low and the full dead time is counted again after release. The zero-cross flag can also coincide with a change of command. Randomised stretches raise zc_det and fault_off on arbitrary edges during command changes and tri-state dwells. A behavioural reference model, stepped every clock, then judges which function wins on each edge.

// File: rtl/gds_pkg.sv
package gds_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_HIGH = 2'd1,
        LVL_MID  = 2'd2
    } lvl_e;

    typedef enum logic [1:0] {
        DRV_OFF = 2'd0,
        DRV_HS  = 2'd1,
        DRV_LS  = 2'd2
    } drv_e;

    typedef struct packed {
        logic hs;
        logic ls;
    } gates_t;

    function automatic lvl_e decode_lvl(input logic [1:0] code);
        if (code[1])
            return LVL_MID;
        else if (code[0])
            return LVL_HIGH;
        else
            return LVL_LOW;
    endfunction

    function automatic gates_t gates_of(input drv_e d);
        gates_t g;
        g.hs = (d == DRV_HS);
        g.ls = (d == DRV_LS);
        return g;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/gds_tri_dwell.sv
module gds_tri_dwell
    import gds_pkg::*;
#(
    parameter int unsigned TRI_CYC = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic kill,
    input  lvl_e lvl,
    output logic tri_valid,
    output logic mid_prev
);
    localparam int unsigned CW = $clog2(TRI_CYC + 1);
    localparam logic [CW-1:0] TOP = CW'(TRI_CYC);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    always_comb begin
        if (lvl == LVL_MID)
            cnt_d = (cnt_q == TOP) ? cnt_q : cnt_q + CW'(1);
        else
            cnt_d = '0;
        tri_valid = (lvl == LVL_MID) && (cnt_d == TOP);
        mid_prev  = (cnt_q != '0);
    end

    always_ff @(posedge clk) begin
        if (rst || kill)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/gds_skip_ctl.sv
module gds_skip_ctl
    import gds_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic kill,
    input  logic skip_sel,
    input  lvl_e lvl,
    input  logic zc,
    output logic skip_now
);
    logic latch_q;

    always_comb begin
        if (lvl == LVL_HIGH || !skip_sel)
            skip_now = 1'b0;
        else
            skip_now = latch_q || (lvl == LVL_LOW && zc);
    end

    always_ff @(posedge clk) begin
        if (rst || kill)
            latch_q <= 1'b0;
        else
            latch_q <= skip_now;
    end
endmodule

// File: rtl/gds_seq.sv
module gds_seq
    import gds_pkg::*;
#(
    parameter int unsigned DEAD_CYC = 4,
    parameter int unsigned QUIT_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic kill,
    input  lvl_e lvl,
    input  logic tri_valid,
    input  logic mid_prev,
    input  logic skip_now,
    output drv_e drv
);
    localparam int unsigned GMAX = max2(DEAD_CYC, QUIT_CYC);
    localparam int unsigned GW   = $clog2(GMAX + 1);
    localparam logic [GW-1:0] GTOP    = GW'(GMAX);
    localparam logic [GW-1:0] DEAD_M1 = GW'(DEAD_CYC - 1);
    localparam logic [GW-1:0] QUIT_M1 = GW'(QUIT_CYC - 1);

    drv_e          drv_q, drv_d;
    drv_e          last_q, last_d;
    drv_e          eff, want;
    logic [GW-1:0] gap_q, gap_d, need_m1;
    logic          in_tri_q, in_tri_d;
    logic          quit_start;

    always_comb begin
        unique case (lvl)
            LVL_HIGH: eff = DRV_HS;
            LVL_LOW:  eff = DRV_LS;
            default:  eff = tri_valid ? DRV_OFF : last_q;
        endcase
        want = (eff == DRV_LS && skip_now) ? DRV_OFF : eff;

        quit_start = in_tri_q && (lvl != LVL_MID) && mid_prev;
        need_m1    = in_tri_q ? QUIT_M1 : DEAD_M1;

        drv_d = drv_q;
        gap_d = (gap_q == GTOP) ? gap_q : gap_q + GW'(1);
        if (drv_q != DRV_OFF) begin
            if (want != drv_q) begin
                drv_d = DRV_OFF;
                gap_d = '0;
            end
        end else if (quit_start) begin
            gap_d = '0;
        end else if (want != DRV_OFF && gap_q >= need_m1) begin
            drv_d = want;
        end

        if (tri_valid)
            in_tri_d = 1'b1;
        else if (drv_d != DRV_OFF)
            in_tri_d = 1'b0;
        else
            in_tri_d = in_tri_q;

        unique case (lvl)
            LVL_HIGH: last_d = DRV_HS;
            LVL_LOW:  last_d = DRV_LS;
            default:  last_d = tri_valid ? DRV_OFF : last_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            drv_q    <= DRV_OFF;
            last_q   <= DRV_OFF;
            gap_q    <= '0;
            in_tri_q <= 1'b0;
        end else begin
            drv_q    <= drv_d;
            last_q   <= last_d;
            gap_q    <= gap_d;
            in_tri_q <= in_tri_d;
        end
    end

    assign drv = drv_q;
endmodule

// File: rtl/gate_drive_seq.sv
module gate_drive_seq
    import gds_pkg::*;
#(
    parameter int unsigned DEAD_CYC = 4,
    parameter int unsigned QUIT_CYC = 8,
    parameter int unsigned TRI_CYC  = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] pwm_code,
    input  logic       pwm_mode,
    input  logic       zc_det,
    input  logic       fault_off,
    output logic       gate_hi,
    output logic       gate_lo
);
    lvl_e   lvl;
    logic   kill;
    logic   tri_valid;
    logic   mid_prev;
    logic   skip_now;
    drv_e   drv;
    gates_t g;

    assign lvl  = decode_lvl(pwm_code);
    assign kill = !en || fault_off;

    gds_tri_dwell #(.TRI_CYC(TRI_CYC)) u_dwell (
        .clk       (clk),
        .rst       (rst),
        .kill      (kill),
        .lvl       (lvl),
        .tri_valid (tri_valid),
        .mid_prev  (mid_prev)
    );

    gds_skip_ctl u_skip (
        .clk      (clk),
        .rst      (rst),
        .kill     (kill),
        .skip_sel (!pwm_mode),
        .lvl      (lvl),
        .zc       (zc_det),
        .skip_now (skip_now)
    );

    gds_seq #(.DEAD_CYC(DEAD_CYC), .QUIT_CYC(QUIT_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .kill      (kill),
        .lvl       (lvl),
        .tri_valid (tri_valid),
        .mid_prev  (mid_prev),
        .skip_now  (skip_now),
        .drv       (drv)
    );

    assign g       = gates_of(drv);
    assign gate_hi = g.hs;
    assign gate_lo = g.ls;
endmodule

// File: rtl/gds_checker.sv
module gds_checker #(
    parameter int unsigned DEAD_CYC = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       fault_off,
    input logic [1:0] pwm_code,
    input logic       pwm_mode,
    input logic       zc_det,
    input logic       gate_hi,
    input logic       gate_lo
);
    localparam int unsigned LW = $clog2(DEAD_CYC + 1);
    localparam logic [LW-1:0] LTOP = LW'(DEAD_CYC);

    logic [LW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || gate_hi || gate_lo)
            low_run <= '0;
        else if (low_run != LTOP)
            low_run <= low_run + LW'(1);
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(gate_hi && gate_lo)); // R4

    AST_KILL_OFF: assert property (@(posedge clk) disable iff (rst)
        (!en || fault_off) |=> (!gate_hi && !gate_lo)); // R2

    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (rst)
        ($rose(gate_hi) || $rose(gate_lo)) |-> (low_run >= LTOP)); // R5

    AST_SKIP_ZC: assert property (@(posedge clk) disable iff (rst)
        (en && !fault_off && !pwm_mode && pwm_code == 2'b00 && zc_det) |=> !gate_lo); // R8

    AST_HIGH_NO_LO: assert property (@(posedge clk) disable iff (rst)
        (pwm_code == 2'b01) |=> !gate_lo); // R3
endmodule

bind gate_drive_seq gds_checker #(.DEAD_CYC(DEAD_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .fault_off (fault_off),
    .pwm_code  (pwm_code),
    .pwm_mode  (pwm_mode),
    .zc_det    (zc_det),
    .gate_hi   (gate_hi),
    .gate_lo   (gate_lo)
);

// File: tb/gate_drive_seq_test.sv
module gate_drive_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEAD = 4;
    localparam int QUIT = 8;
    localparam int TRIW = 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [1:0] pwm_code = 2'b00;
    logic       pwm_mode = 1'b1;
    logic       zc_det = 1'b0;
    logic       fault_off = 1'b0;
    logic       gate_hi;
    logic       gate_lo;

    int    n_cmp = 0;
    int    n_bad = 0;
    string phase = "R1";

    // reference model state: drive 0 none, 1 high side, 2 low side
    int m_drv = 0, m_gap = 0, m_intri = 0, m_tri = 0, m_skip = 0, m_last = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gate_drive_seq #(.DEAD_CYC(DEAD), .QUIT_CYC(QUIT), .TRI_CYC(TRIW)) uut (
        .clk(clk), .rst(rst), .en(en), .pwm_code(pwm_code), .pwm_mode(pwm_mode),
        .zc_det(zc_det), .fault_off(fault_off), .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    always @(posedge clk) begin
        int nd, want, eff, need, tv, prevmid, isl, ish, ism;
        if (rst || !en || fault_off) begin
            m_drv = 0; m_gap = 0; m_intri = 0; m_tri = 0; m_skip = 0; m_last = 0;
        end else begin
            ish = (pwm_code == 2'b01);
            isl = (pwm_code == 2'b00);
            ism = pwm_code[1];
            prevmid = (m_tri > 0);
            if (ism) begin
                if (m_tri < TRIW) m_tri = m_tri + 1;
            end else m_tri = 0;
            tv = ism && (m_tri == TRIW);
            if (ish || pwm_mode) m_skip = 0;
            else if (isl && zc_det) m_skip = 1;
            eff = ish ? 1 : (isl ? 2 : (tv ? 0 : m_last));
            want = (eff == 2 && m_skip) ? 0 : eff;
            need = m_intri ? QUIT : DEAD;
            nd = m_drv;
            if (m_drv != 0) begin
                if (want != m_drv) begin nd = 0; m_gap = 0; end
            end else if (m_intri && !ism && prevmid) begin
                m_gap = 0;
            end else if (want != 0 && m_gap + 1 >= need) begin
                nd = want;
            end else if (m_gap < QUIT) begin
                m_gap = m_gap + 1;
            end
            if (tv) m_intri = 1;
            else if (nd != 0) m_intri = 0;
            m_last = ish ? 1 : (isl ? 2 : (tv ? 0 : m_last));
            m_drv = nd;
        end
    end

    task automatic tick();
        logic eh, el;
        @(posedge clk);
        @(negedge clk);
        eh = (m_drv == 1);
        el = (m_drv == 2);
        n_cmp++;
        if (gate_hi !== eh || gate_lo !== el) begin
            n_bad++;
            $display("FAIL %s model: actual hi=%b lo=%b expected hi=%b lo=%b at %0t",
                     phase, gate_hi, gate_lo, eh, el, $time);
        end
        if (gate_hi === 1'b1 && gate_lo === 1'b1) begin
            n_bad++;
            $display("FAIL R4 overlap: actual hi=1 lo=1 expected not both at %0t", $time);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic expect_gates(input string tag, input logic eh, input logic el);
        n_cmp++;
        if (gate_hi !== eh || gate_lo !== el) begin
            n_bad++;
            $display("FAIL %s directed: actual hi=%b lo=%b expected hi=%b lo=%b at %0t",
                     tag, gate_hi, gate_lo, eh, el, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL R4 watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        run(3);
        expect_gates("R1", 0, 0);
        rst = 1'b0;
        en = 1'b1; pwm_mode = 1'b1; pwm_code = 2'b01;
        phase = "R1";
        run(3);
        expect_gates("R1", 0, 0);
        tick();
        expect_gates("R3", 1, 0);

        // R5: high to low with dead time
        phase = "R5";
        pwm_code = 2'b00;
        tick();
        expect_gates("R5", 0, 0);
        run(3);
        expect_gates("R5", 0, 0);
        tick();
        expect_gates("R3", 0, 1);

        // R3: regular switching
        phase = "R3";
        for (int p = 0; p < 5; p++) begin
            pwm_code = 2'b01; run(20);
            expect_gates("R3", 1, 0);
            pwm_code = 2'b00; run(40);
            expect_gates("R3", 0, 1);
        end

        // R6: short tri dwell ignored, long dwell turns off
        phase = "R6";
        pwm_code = 2'b10; run(10);
        expect_gates("R6", 0, 1);
        pwm_code = 2'b00; run(5);
        pwm_code = 2'b11; run(TRIW - 1);
        expect_gates("R6", 0, 1);
        tick();
        expect_gates("R6", 0, 0);
        run(10);

        // R7: quit delay
        phase = "R7";
        pwm_code = 2'b01;
        run(QUIT);
        expect_gates("R7", 0, 0);
        tick();
        expect_gates("R7", 1, 0);
        run(10);

        // R8 / R9: skip mode
        phase = "R8";
        pwm_mode = 1'b0;
        pwm_code = 2'b00; run(10);
        expect_gates("R8", 0, 1);
        zc_det = 1'b1; tick();
        expect_gates("R8", 0, 0);
        phase = "R9";
        zc_det = 1'b0; run(10);
        expect_gates("R9", 0, 0);
        pwm_code = 2'b01; tick();
        expect_gates("R9", 1, 0);
        run(10);
        pwm_code = 2'b00; run(10);
        expect_gates("R9", 0, 1);

        // R10: forced PWM ignores zero cross
        phase = "R10";
        pwm_mode = 1'b1;
        zc_det = 1'b1; run(10);
        expect_gates("R10", 0, 1);
        zc_det = 1'b0;

        // R2: fault on the edge a turn-on is due
        phase = "R2";
        pwm_code = 2'b01;
        tick();
        expect_gates("R5", 0, 0);
        run(DEAD);
        expect_gates("R2", 1, 0);
        pwm_code = 2'b00;
        tick();
        run(DEAD - 2);
        expect_gates("R2", 0, 0);
        fault_off = 1'b1; tick();
        expect_gates("R2", 0, 0);
        run(2);
        fault_off = 1'b0;
        run(DEAD - 1);
        expect_gates("R2", 0, 0);
        tick();
        expect_gates("R2", 0, 1);
        en = 1'b0; tick();
        expect_gates("R2", 0, 0);
        run(3);
        expect_gates("R2", 0, 0);
        en = 1'b1; run(DEAD);
        expect_gates("R2", 0, 1);

        // R4: randomised mix
        phase = "R4";
        for (int s = 0; s < 400; s++) begin
            int sel;
            int dwell;
            sel = $urandom_range(0, 9);
            pwm_code = (sel < 4) ? 2'b01 : (sel < 8) ? 2'b00 : (sel == 8 ? 2'b10 : 2'b11);
            pwm_mode = ($urandom_range(0, 3) != 0) ? 1'b0 : 1'b1;
            dwell = (sel >= 8) ? $urandom_range(5, 40) : $urandom_range(1, 30);
            for (int k = 0; k < dwell; k++) begin
                zc_det = ($urandom_range(0, 5) == 0);
                fault_off = ($urandom_range(0, 60) == 0);
                en = ($urandom_range(0, 80) != 0);
                tick();
            end
        end
        fault_off = 1'b0; en = 1'b1; zc_det = 1'b0;
        run(5);

        summary();
        $finish;
    end
endmodule